// File: doc/BRIEF.md
# Amplitude Ramp Keying Controller

This block produces the unsigned amplitude word that scales the output of a direct digital synthesizer. A 32-bit parameter word is loaded in parallel under a strobe. It carries three things: a step-interval count, a scale factor that is either the ceiling or the fixed level, and a step-size code. Three live control inputs decide the behaviour: an enable, an automatic/manual select and a manual gating select. A keying pin completes the controls.

In manual operation the programmed scale factor is passed to the output. When gating is selected, the keying pin can force the output to zero. In automatic operation the block ramps the amplitude linearly. It moves one step per interval, rising toward the ceiling while the pin is high and falling toward zero while it is low. The direction can reverse at any moment.

The controller is a five-state machine: `ARK_OFF` (disabled), `ARK_PASS` (manual, scale factor out), `ARK_MUTE` (manual, gated to zero), `ARK_RISE` and `ARK_FALL` (automatic ramp). Every clock it moves to the state chosen by the inputs:
- disable gives OFF;
- manual with gating and pin low gives MUTE;
- other manual cases give PASS;
- automatic with pin high gives RISE, and with pin low gives FALL.

All transitions between any two states are direct. A prescaler divides the clock by four. An interval timer counts the prescaler ticks and issues a step pulse every M ticks. A saturating stepper holds the ramp value.

Top module: `ark_ctrl`

## Requirements
- R1: After reset the amplitude output is 0.
- R2: While the enable is 0 the output is 0 from the next cycle on, the other controls and the pin have no effect, and the step timer is held cleared. After re-enabling into automatic mode, the first step lands 4·M+1 cycles later.
- R3: The parameter word is split as follows: bits 31:16 are the interval count M, bits 15:2 are the 14-bit scale factor, and bits 1:0 are the step code. A word presented with the load strobe is in effect in the cycle after the strobe. Without the strobe the word is ignored.
- R4: In manual mode with gating clear, the output equals the scale factor whatever the pin does.
- R5: In manual mode with gating set, pin 0 makes the output 0 and pin 1 makes it equal the scale factor. The change appears one cycle after the pin changes.
- R6: In automatic mode, steps occur every 4·M cycles. The first step comes 4·M+1 cycles after automatic mode is entered. Step codes 0, 1, 2 and 3 add 1, 2, 4 and 8 output LSBs.
- R7: A rising ramp saturates at the scale factor and never exceeds it.
- R8: A falling ramp decreases by the step from its present value and saturates at 0.
- R9: A pin change reverses the direction from the current value. The interval phase is kept.
- R10: An interval count M of 0 behaves as M = 1.
- R11: Leaving automatic mode clears the ramp, so a new automatic period starts from 0.
- R12: A load restarts the interval timer, so the next step comes 4·M+1 cycles after the load strobe, using the new M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_data | input | 32 | Parameter word: interval count, scale factor, step code |
| cfg_load | input | 1 | Strobe that applies cfg_data |
| en | input | 1 | Block enable |
| auto_sel | input | 1 | 1 = automatic ramp, 0 = manual |
| ext_gate | input | 1 | Manual mode: lets the keying pin gate the output |
| key_in | input | 1 | Keying pin: ramp direction or manual gate |
| amp_out | output | 14 | Amplitude control word |

## Verification
The bench builds the controller with its default widths: a 14-bit amplitude, a 16-bit interval count, a 2-bit step code and a divide-by-four prescaler. Because the interval count comes from the loaded word, small values of M (0 to 3) keep each step within a dozen cycles. Small ceilings such as 5 and 20 then bring saturation, reversal near both limits and the largest step code within a few hundred cycles. Exact step cycles are predicted from the 4·M+1 rule, so the scoreboard can tell a timer restart on load from a free-running timer.

// File: rtl/ark_pkg.sv
package ark_pkg;

    typedef enum logic [2:0] {
        ARK_OFF  = 3'd0,
        ARK_PASS = 3'd1,
        ARK_MUTE = 3'd2,
        ARK_RISE = 3'd3,
        ARK_FALL = 3'd4
    } ark_state_e;

endpackage

// File: rtl/ark_prescaler.sv
module ark_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ph_q <= '0;
        else if (clr)
            ph_q <= '0;
        else if (ph_q == LAST)
            ph_q <= '0;
        else
            ph_q <= ph_q + PW'(1);
    end

    assign tick = !clr && (ph_q == LAST);

    // R6
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/ark_interval_timer.sv
module ark_interval_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] rate,
    output logic          step
);
    logic [CW-1:0] lim;
    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign lim  = (rate == '0) ? CW'(1) : rate;
    assign wrap = (cnt_q == lim - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= wrap ? '0 : cnt_q + CW'(1);
    end

    assign step = tick && wrap;

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < lim);

    // R12
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/ark_ramp_stepper.sv
module ark_ramp_stepper #(
    parameter int AW = 14,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          rising,
    input  logic          step,
    input  logic [SW-1:0] code,
    input  logic [AW-1:0] ceiling,
    output logic [AW-1:0] ramp
);
    logic [AW:0]   inc;
    logic [AW:0]   cur_ext;
    logic [AW:0]   ceil_ext;
    logic [AW:0]   up_val;
    logic [AW:0]   dn_val;
    logic [AW:0]   cand;
    logic [AW-1:0] ramp_nxt;
    logic [AW-1:0] ramp_q;

    assign inc      = (AW + 1)'(1) << code;
    assign cur_ext  = {1'b0, ramp_q};
    assign ceil_ext = {1'b0, ceiling};
    assign up_val   = cur_ext + inc;
    assign dn_val   = (cur_ext > inc) ? cur_ext - inc : '0;

    always_comb begin
        if (step)
            cand = rising ? up_val : dn_val;
        else
            cand = cur_ext;
        if (!active)
            ramp_nxt = '0;
        else if (cand > ceil_ext)
            ramp_nxt = ceiling;
        else
            ramp_nxt = cand[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ramp_q <= '0;
        else
            ramp_q <= ramp_nxt;
    end

    assign ramp = ramp_q;

    // R7
    ceil_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && $past(active) && $stable(ceiling) |-> ramp_q <= ceiling);

    // R11
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ramp_q == '0);

    // R6
    no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && !step && ramp_q <= ceiling |=> ramp_q == $past(ramp_q) || !$past(active));

endmodule

// File: rtl/ark_ctrl.sv
module ark_ctrl #(
    parameter int AMP_W = 14,
    parameter int RATE_W = 16,
    parameter int CODE_W = 2,
    parameter int PRE_DIV = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [RATE_W+AMP_W+CODE_W-1:0]     cfg_data,
    input  logic                               cfg_load,
    input  logic                               en,
    input  logic                               auto_sel,
    input  logic                               ext_gate,
    input  logic                               key_in,
    output logic [AMP_W-1:0]                   amp_out
);
    import ark_pkg::*;

    localparam int REG_W   = RATE_W + AMP_W + CODE_W;
    localparam int CODE_LO = 0;
    localparam int SF_LO   = CODE_W;
    localparam int SF_HI   = SF_LO + AMP_W - 1;
    localparam int RATE_LO = SF_HI + 1;
    localparam int RATE_HI = REG_W - 1;

    logic [REG_W-1:0]  cfg_q;
    logic [RATE_W-1:0] rate_q;
    logic [AMP_W-1:0]  scale_q;
    logic [CODE_W-1:0] code_q;

    ark_state_e state_q, state_nxt;
    logic run, rising, tmr_clr, pre_tick, step;
    logic [AMP_W-1:0] ramp;

    // parameter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_load)
            cfg_q <= cfg_data;
    end

    assign rate_q  = cfg_q[RATE_HI:RATE_LO];
    assign scale_q = cfg_q[SF_HI:SF_LO];
    assign code_q  = cfg_q[CODE_LO +: CODE_W];

    // next-state selection
    always_comb begin
        if (!en)
            state_nxt = ARK_OFF;
        else if (!auto_sel)
            state_nxt = (ext_gate && !key_in) ? ARK_MUTE : ARK_PASS;
        else
            state_nxt = key_in ? ARK_RISE : ARK_FALL;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ARK_OFF;
        else
            state_q <= state_nxt;
    end

    assign run     = (state_q == ARK_RISE) || (state_q == ARK_FALL);
    assign rising  = (state_q == ARK_RISE);
    assign tmr_clr = cfg_load || !run;

    ark_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (pre_tick)
    );

    ark_interval_timer #(.CW(RATE_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (pre_tick),
        .rate  (rate_q),
        .step  (step)
    );

    ark_ramp_stepper #(.AW(AMP_W), .SW(CODE_W)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (run),
        .rising  (rising),
        .step    (step),
        .code    (code_q),
        .ceiling (scale_q),
        .ramp    (ramp)
    );

    // output process
    always_comb begin
        unique case (state_q)
            ARK_OFF:  amp_out = '0;
            ARK_MUTE: amp_out = '0;
            ARK_PASS: amp_out = scale_q;
            ARK_RISE,
            ARK_FALL: amp_out = (ramp > scale_q) ? scale_q : ramp;
            default:  amp_out = '0;
        endcase
    end

    // R2
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> amp_out == '0);

    // R5
    mute_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && !auto_sel && ext_gate && !key_in |=> amp_out == '0);

    // R3
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> scale_q == $past(cfg_data[SF_HI:SF_LO]));

    // R4
    pass_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && !auto_sel && !ext_gate && !cfg_load |=> amp_out == $past(scale_q));

endmodule

// File: tb/tb_ark_ctrl.sv
module tb_ark_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        cfg_load = 1'b0;
    logic        en = 1'b0;
    logic        auto_sel = 1'b0;
    logic        ext_gate = 1'b0;
    logic        key_in = 1'b0;
    logic [13:0] amp_out;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        logic [13:0] val;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    ark_ctrl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_data (cfg_data),
        .cfg_load (cfg_load),
        .en       (en),
        .auto_sel (auto_sel),
        .ext_gate (ext_gate),
        .key_in   (key_in),
        .amp_out  (amp_out)
    );

    function automatic logic [31:0] mk(input int m, input int sf, input int code);
        return {m[15:0], sf[13:0], code[1:0]};
    endfunction

    task automatic expect_at(input int n, input int v, input string tag);
        sb_item_t it;
        it.at  = cyc + n;
        it.val = v[13:0];
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // monitor: pops and compares expected items
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            sb_item_t it;
            it = sb.pop_front();
            checks++;
            if (it.at != cyc || amp_out !== it.val) begin
                errors++;
                $display("FAIL %s cycle %0d: amp_out actual %0d expected %0d",
                         it.tag, cyc, amp_out, it.val);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t, t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_at(1, 0, "R1");
        expect_at(2, 0, "R1");
        wait_until(cyc + 3);

        // manual pass with load (R3, R4)
        @(negedge clk);
        en = 1'b1; cfg_data = mk(2, 100, 1); cfg_load = 1'b1;
        expect_at(1, 100, "R3");
        @(negedge clk);
        cfg_load = 1'b0; cfg_data = mk(2, 33, 1); key_in = 1'b1;
        expect_at(1, 100, "R3");
        @(negedge clk);
        key_in = 1'b0;
        expect_at(1, 100, "R4");
        // gating (R5)
        @(negedge clk);
        ext_gate = 1'b1;
        expect_at(1, 0, "R5");
        @(negedge clk);
        key_in = 1'b1;
        expect_at(1, 100, "R5");
        @(negedge clk);
        key_in = 1'b0; ext_gate = 1'b0;
        expect_at(1, 100, "R4");
        @(negedge clk);

        // rising ramp, step 2, ceiling 5 (R6, R7)
        cfg_data = mk(1, 5, 1); cfg_load = 1'b1;
        expect_at(1, 5, "R3");
        @(negedge clk);
        cfg_load = 1'b0; auto_sel = 1'b1; key_in = 1'b1;
        t = cyc;
        expect_at(4, 0, "R6");
        expect_at(5, 2, "R6");
        expect_at(8, 2, "R6");
        expect_at(9, 4, "R6");
        expect_at(13, 5, "R7");
        expect_at(17, 5, "R7");
        wait_until(t + 17);
        // falling (R8)
        key_in = 1'b0;
        expect_at(4, 3, "R8");
        expect_at(8, 1, "R8");
        expect_at(12, 0, "R8");
        expect_at(16, 0, "R8");
        wait_until(cyc + 16);

        // leave auto, then M=0 with code 3 (R11, R10)
        @(negedge clk);
        auto_sel = 1'b0;
        expect_at(1, 5, "R11");
        @(negedge clk);
        @(negedge clk);
        cfg_data = mk(0, 20, 3); cfg_load = 1'b1; auto_sel = 1'b1; key_in = 1'b1;
        expect_at(1, 0, "R11");
        expect_at(4, 0, "R10");
        expect_at(5, 8, "R10");
        expect_at(9, 16, "R10");
        expect_at(13, 20, "R7");
        t = cyc;
        @(negedge clk);
        cfg_load = 1'b0;
        wait_until(t + 14);

        // load restart and reversal (R12, R9)
        auto_sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cfg_data = mk(3, 100, 0); cfg_load = 1'b1; auto_sel = 1'b1; key_in = 1'b1;
        t = cyc;
        expect_at(12, 0, "R6");
        expect_at(13, 1, "R6");
        @(negedge clk);
        cfg_load = 1'b0;
        wait_until(t + 20);
        cfg_data = mk(2, 100, 0); cfg_load = 1'b1;
        t1 = cyc;
        expect_at(5, 1, "R12");
        expect_at(8, 1, "R12");
        expect_at(9, 2, "R12");
        @(negedge clk);
        cfg_load = 1'b0;
        wait_until(t1 + 17);
        key_in = 1'b0;
        t2 = cyc;
        expect_at(7, 3, "R9");
        expect_at(8, 2, "R9");
        expect_at(16, 1, "R9");
        wait_until(t2 + 16);
        key_in = 1'b1;
        expect_at(8, 2, "R9");
        wait_until(cyc + 8);

        // disable (R2)
        @(negedge clk);
        en = 1'b0;
        expect_at(1, 0, "R2");
        @(negedge clk);
        auto_sel = 1'b0; ext_gate = 1'b0;
        expect_at(1, 0, "R2");
        @(negedge clk);
        key_in = 1'b0;
        expect_at(1, 0, "R2");
        @(negedge clk);
        @(negedge clk);
        en = 1'b1; auto_sel = 1'b1; key_in = 1'b1;
        expect_at(8, 0, "R2");
        expect_at(9, 1, "R2");
        wait_until(cyc + 10);

        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule